// File: doc/BRIEF.md
# Range TLB Invalidation Controller

This block drives invalidations into the translation caches of an address-translation unit. Software programs it through a small word-addressed register port. It writes a unit-select mask, a first page address, a last page address and finally a command word. Two commands exist. One discards every cached translation in a single strobe. The other discards the pages from the first address to the last address, both included, one page per clock.

The strobe output carries a valid bit, a page number, an all-entries flag and the unit mask, and the translation caches watch it. A range operation finishes by setting a sticky completion register. Software polls that register and clears it by writing zero. A busy bit is readable while a range walk is in progress. Commands that arrive during a walk are dropped.

Top module: `tlb_rinv_ctrl`

## Requirements
- R1: After reset every readable register returns 0, no strobe is issued and busy is 0.
- R2: Register word indexes are: 0 unit select, 1 first page, 2 last page, 3 command, 4 completion, 5 status with busy in bit 0. Unmapped indexes read 0. The select register keeps wdata[1:0]. The address registers keep wdata[31:12] and read back with bits [11:0] zero.
- R3: Writing command value 0x2 while idle produces exactly one strobe cycle in the cycle after the write, with the all flag 1 and the unit field equal to the select register. Busy stays 0 and the completion register is not changed.
- R4: Writing command value 0x1 while idle issues one strobe per clock with the all flag 0. The pages run from the first page to the last page inclusive, in ascending order, starting in the cycle after the write. The unit field equals the select register, and busy is 1 in every strobe cycle.
- R5: In the cycle after the last strobe of a range, the completion register reads 1 and busy reads 0.
- R6: The completion register stays set until a write of zero to index 4. A nonzero write there has no effect.
- R7: A command written while busy is ignored. Any command value other than 0x1 and 0x2 is ignored.
- R8: When the select register is 0 or the last page is below the first page, a range command issues no strobe and sets completion in the cycle after the write. A flush-all command with select 0 issues no strobe.
- R9: Writes to the select and address registers during a walk do not change the pages or the unit field of that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| inv_valid | output | 1 | Invalidate strobe |
| inv_all | output | 1 | Strobe applies to every entry |
| inv_page | output | 20 | Page number to invalidate |
| inv_unit | output | 2 | Mask of translation caches that take the strobe |

## Verification
If the page counter is wrong inside the walker, the error appears on inv_page in the very next strobe cycle. A stuck run flag shows up as a strobe count that differs from the inclusive page span. An end comparison that is off by one shows at the last page and in the cycle when completion rises. A completion flag that is lost or set spuriously shows on the completion read one cycle after the walk ends, or after a flush-all. An open busy gate shows at once, because a command written mid-walk raises the all flag or restarts the page sequence.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;
    localparam int REG_IDX_W = 3;

    // register word indexes
    localparam logic [REG_IDX_W-1:0] IDX_UNIT   = 3'd0;
    localparam logic [REG_IDX_W-1:0] IDX_FIRST  = 3'd1;
    localparam logic [REG_IDX_W-1:0] IDX_LAST   = 3'd2;
    localparam logic [REG_IDX_W-1:0] IDX_CMD    = 3'd3;
    localparam logic [REG_IDX_W-1:0] IDX_DONE   = 3'd4;
    localparam logic [REG_IDX_W-1:0] IDX_STATUS = 3'd5;

    // command codes
    localparam logic [31:0] CMD_RANGE = 32'h1;
    localparam logic [31:0] CMD_ALL   = 32'h2;
endpackage

// File: rtl/tlbinv_cmd_decode.sv
module tlbinv_cmd_decode
    import tlbinv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int VPN_W  = 20,
    parameter int UNITS  = 2
) (
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 busy,
    input  logic [UNITS-1:0]     unit_mask,
    input  logic [VPN_W-1:0]     first_vpn,
    input  logic [VPN_W-1:0]     last_vpn,
    output logic                 wr_unit,
    output logic                 wr_first,
    output logic                 wr_last,
    output logic                 done_clr,
    output logic                 go_all,
    output logic                 go_range,
    output logic                 range_empty
);
    logic cmd_wr;
    logic is_range;
    logic is_all;
    logic no_unit;
    logic backwards;

    always_comb begin
        wr_unit   = we && (addr == IDX_UNIT);
        wr_first  = we && (addr == IDX_FIRST);
        wr_last   = we && (addr == IDX_LAST);
        done_clr  = we && (addr == IDX_DONE) && (wdata == '0);
        cmd_wr    = we && (addr == IDX_CMD) && !busy;
        is_range  = (wdata == DATA_W'(CMD_RANGE));
        is_all    = (wdata == DATA_W'(CMD_ALL));
        no_unit   = (unit_mask == '0);
        backwards = (last_vpn < first_vpn);

        go_all      = cmd_wr && is_all && !no_unit;
        go_range    = cmd_wr && is_range && !no_unit && !backwards;
        range_empty = cmd_wr && is_range && (no_unit || backwards);
    end
endmodule

// File: rtl/tlbinv_walker.sv
module tlbinv_walker #(
    parameter int VPN_W = 20,
    parameter int UNITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_all,
    input  logic             go_range,
    input  logic [VPN_W-1:0] first_vpn,
    input  logic [VPN_W-1:0] last_vpn,
    input  logic [UNITS-1:0] unit_mask,
    output logic             busy,
    output logic             finish,
    output logic             inv_valid,
    output logic             inv_all,
    output logic [VPN_W-1:0] inv_page,
    output logic [UNITS-1:0] inv_unit
);
    typedef struct packed {
        logic             run;
        logic             all;
        logic [VPN_W-1:0] cur;
        logic [VPN_W-1:0] lim;
        logic [UNITS-1:0] unit;
    } walk_t;

    walk_t walk_d, walk_q;
    logic  at_last;

    always_comb begin
        walk_d  = walk_q;
        at_last = walk_q.run && (walk_q.cur == walk_q.lim);
        finish  = at_last;

        walk_d.all = go_all;
        if (walk_q.run) begin
            if (at_last) begin
                walk_d.run = 1'b0;
            end else begin
                walk_d.cur = walk_q.cur + VPN_W'(1);
            end
        end else if (go_range) begin
            walk_d.run  = 1'b1;
            walk_d.cur  = first_vpn;
            walk_d.lim  = last_vpn;
            walk_d.unit = unit_mask;
        end
        if (go_all) begin
            walk_d.unit = unit_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign busy      = walk_q.run;
    assign inv_valid = walk_q.run || walk_q.all;
    assign inv_all   = walk_q.all;
    assign inv_page  = walk_q.all ? '0 : walk_q.cur;
    assign inv_unit  = walk_q.unit;
endmodule

// File: rtl/tlbinv_readmux.sv
module tlbinv_readmux
    import tlbinv_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int VPN_W      = 20,
    parameter int PAGE_SHIFT = 12,
    parameter int UNITS      = 2
) (
    input  logic [REG_IDX_W-1:0] addr,
    input  logic [UNITS-1:0]     unit_mask,
    input  logic [VPN_W-1:0]     first_vpn,
    input  logic [VPN_W-1:0]     last_vpn,
    input  logic                 done,
    input  logic                 busy,
    output logic [DATA_W-1:0]    rdata
);
    localparam logic [PAGE_SHIFT-1:0] PAGE_ZERO = '0;

    always_comb begin
        unique case (addr)
            IDX_UNIT:   rdata = DATA_W'(unit_mask);
            IDX_FIRST:  rdata = DATA_W'({first_vpn, PAGE_ZERO});
            IDX_LAST:   rdata = DATA_W'({last_vpn, PAGE_ZERO});
            IDX_DONE:   rdata = DATA_W'(done);
            IDX_STATUS: rdata = DATA_W'(busy);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/tlb_rinv_ctrl.sv
module tlb_rinv_ctrl
    import tlbinv_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int UNITS      = 2,
    localparam int VPN_W     = DATA_W - PAGE_SHIFT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [REG_IDX_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 inv_valid,
    output logic                 inv_all,
    output logic [VPN_W-1:0]     inv_page,
    output logic [UNITS-1:0]     inv_unit
);
    typedef struct packed {
        logic [UNITS-1:0] unit;
        logic [VPN_W-1:0] first;
        logic [VPN_W-1:0] last;
        logic             done;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic busy;
    logic finish;
    logic wr_unit, wr_first, wr_last, done_clr;
    logic go_all, go_range, range_empty;

    tlbinv_cmd_decode #(
        .DATA_W (DATA_W),
        .VPN_W  (VPN_W),
        .UNITS  (UNITS)
    ) i_decode (
        .we          (reg_we),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .busy        (busy),
        .unit_mask   (cfg_q.unit),
        .first_vpn   (cfg_q.first),
        .last_vpn    (cfg_q.last),
        .wr_unit     (wr_unit),
        .wr_first    (wr_first),
        .wr_last     (wr_last),
        .done_clr    (done_clr),
        .go_all      (go_all),
        .go_range    (go_range),
        .range_empty (range_empty)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (wr_unit) begin
            cfg_d.unit = reg_wdata[UNITS-1:0];
        end
        if (wr_first) begin
            cfg_d.first = reg_wdata[DATA_W-1:PAGE_SHIFT];
        end
        if (wr_last) begin
            cfg_d.last = reg_wdata[DATA_W-1:PAGE_SHIFT];
        end
        // completion set takes priority over a clear in the same cycle
        if (finish || range_empty) begin
            cfg_d.done = 1'b1;
        end else if (done_clr) begin
            cfg_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    tlbinv_walker #(
        .VPN_W (VPN_W),
        .UNITS (UNITS)
    ) i_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_all    (go_all),
        .go_range  (go_range),
        .first_vpn (cfg_q.first),
        .last_vpn  (cfg_q.last),
        .unit_mask (cfg_q.unit),
        .busy      (busy),
        .finish    (finish),
        .inv_valid (inv_valid),
        .inv_all   (inv_all),
        .inv_page  (inv_page),
        .inv_unit  (inv_unit)
    );

    tlbinv_readmux #(
        .DATA_W     (DATA_W),
        .VPN_W      (VPN_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .UNITS      (UNITS)
    ) i_readmux (
        .addr      (reg_addr),
        .unit_mask (cfg_q.unit),
        .first_vpn (cfg_q.first),
        .last_vpn  (cfg_q.last),
        .done      (cfg_q.done),
        .busy      (busy),
        .rdata     (reg_rdata)
    );
endmodule

// File: rtl/tlbinv_checker.sv
module tlbinv_checker
    import tlbinv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int VPN_W  = 20,
    parameter int UNITS  = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic [REG_IDX_W-1:0] reg_addr,
    input logic [DATA_W-1:0]    reg_wdata,
    input logic                 inv_valid,
    input logic                 inv_all,
    input logic [VPN_W-1:0]     inv_page,
    input logic [UNITS-1:0]     inv_unit,
    input logic                 busy,
    input logic                 done
);
    AST_STROBE_HAS_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_unit != '0)); // R8

    AST_ALL_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |-> (inv_valid && !busy)); // R3

    AST_BUSY_MEANS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (inv_valid && !inv_all)); // R4

    AST_PAGE_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && inv_valid) |=> (!inv_valid || inv_page == $past(inv_page) + VPN_W'(1))); // R4

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R5

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !(reg_we && reg_addr == IDX_DONE && reg_wdata == '0)) |=> done); // R6

    AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == IDX_CMD) |=> !inv_all); // R7
endmodule

bind tlb_rinv_ctrl tlbinv_checker #(
    .DATA_W (DATA_W),
    .VPN_W  (VPN_W),
    .UNITS  (UNITS)
) i_tlbinv_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .inv_valid (inv_valid),
    .inv_all   (inv_all),
    .inv_page  (inv_page),
    .inv_unit  (inv_unit),
    .busy      (busy),
    .done      (cfg_q.done)
);

// File: tb/test_tlb_rinv_ctrl.sv
`timescale 1ns/1ps
module test_tlb_rinv_ctrl;
    localparam int CYC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        inv_valid;
    logic        inv_all;
    logic [19:0] inv_page;
    logic [1:0]  inv_unit;

    int total = 0;
    int bad = 0;

    always #(CYC/2) clk = ~clk;

    tlb_rinv_ctrl i_tlb_rinv_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .inv_valid (inv_valid),
        .inv_all   (inv_all),
        .inv_page  (inv_page),
        .inv_unit  (inv_unit)
    );

    // {unit[1:0], first vpn[19:0], last vpn[19:0]}
    localparam int NVEC = 5;
    localparam logic [41:0] VEC [NVEC] = '{
        {2'd3, 20'h00010, 20'h00013},
        {2'd1, 20'h12345, 20'h12345},
        {2'd2, 20'hFFFFD, 20'hFFFFF},
        {2'd3, 20'h00020, 20'h0001F},
        {2'd0, 20'h00001, 20'h00004}
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // call at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #(CYC * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic        saw_all;
        int          cnt;
        logic [19:0] base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), r);
            chk(r == 0, "R1 reset read", r, 0);
        end
        chk(inv_valid == 1'b0, "R1 no strobe", 32'(inv_valid), 0);

        // R2: masking and readback, unmapped index
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, r); chk(r == 32'h3, "R2 unit", r, 32'h3);
        wr(3'd1, 32'h1234_5ABC); rd(3'd1, r); chk(r == 32'h1234_5000, "R2 first", r, 32'h1234_5000);
        wr(3'd2, 32'hFEDC_BFFF); rd(3'd2, r); chk(r == 32'hFEDC_B000, "R2 last", r, 32'hFEDC_B000);
        rd(3'd7, r); chk(r == 0, "R2 unmapped", r, 0);

        // R3: flush-all
        wr(3'd0, 32'h2);
        wr(3'd3, 32'h2);
        chk(inv_valid && inv_all, "R3 strobe", {30'b0, inv_valid, inv_all}, 3);
        chk(inv_unit == 2'd2, "R3 unit", 32'(inv_unit), 2);
        rd(3'd5, r); chk(r == 0, "R3 not busy", r, 0);
        rd(3'd4, r); chk(r == 0, "R3 done untouched", r, 0);
        @(negedge clk);
        chk(!inv_valid, "R3 single cycle", 32'(inv_valid), 0);

        // R8: flush-all with no unit selected
        wr(3'd0, 32'h0);
        wr(3'd3, 32'h2);
        chk(!inv_valid, "R8 all no unit", 32'(inv_valid), 0);

        // R7: unknown command value
        wr(3'd0, 32'h3);
        wr(3'd3, 32'h3);
        chk(!inv_valid, "R7 bad cmd", 32'(inv_valid), 0);
        rd(3'd5, r); chk(r == 0, "R7 bad cmd busy", r, 0);

        // R4 R5 R6 R8: vector table of range walks
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0]  u;
            logic [19:0] f;
            logic [19:0] l;
            int          n;
            {u, f, l} = VEC[v];
            n = (u != 0 && l >= f) ? int'(l - f) + 1 : 0;
            wr(3'd0, {30'b0, u});
            wr(3'd1, {f, 12'hABC});
            wr(3'd2, {l, 12'h123});
            wr(3'd3, 32'h1);
            for (int i = 0; i < n; i++) begin
                chk(inv_valid && !inv_all, "R4 strobe", {30'b0, inv_valid, inv_all}, 2);
                chk(inv_page == f + 20'(i), "R4 page", 32'(inv_page), 32'(f + 20'(i)));
                chk(inv_unit == u, "R4 unit", 32'(inv_unit), 32'(u));
                rd(3'd5, r); chk(r == 1, "R4 busy", r, 1);
                @(negedge clk);
            end
            chk(!inv_valid, n == 0 ? "R8 no strobe" : "R5 end of strobes", 32'(inv_valid), 0);
            rd(3'd4, r); chk(r == 1, n == 0 ? "R8 done" : "R5 done", r, 1);
            rd(3'd5, r); chk(r == 0, "R5 idle", r, 0);
            wr(3'd4, 32'h5); rd(3'd4, r); chk(r == 1, "R6 nonzero write", r, 1);
            @(negedge clk);
            rd(3'd4, r); chk(r == 1, "R6 sticky", r, 1);
            wr(3'd4, 32'h0); rd(3'd4, r); chk(r == 0, "R6 clear", r, 0);
        end

        // R7 R9: commands and reprogramming during a walk
        base = 20'h00400;
        wr(3'd0, 32'h1);
        wr(3'd1, {base, 12'h0});
        wr(3'd2, {base + 20'd7, 12'h0});
        wr(3'd3, 32'h1);
        saw_all = 1'b0;
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            if (inv_valid) cnt++;
            if (inv_all) saw_all = 1'b1;
            chk(inv_page == base + 20'(i), "R9 page", 32'(inv_page), 32'(base + 20'(i)));
            chk(inv_unit == 2'd1, "R9 unit", 32'(inv_unit), 1);
            reg_we = 1'b0;
            if (i == 1) begin reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h2; end
            if (i == 2) begin reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = {base, 12'h0}; end
            if (i == 3) begin reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h2; end
            if (i == 4) begin reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h1; end
            @(negedge clk);
        end
        reg_we = 1'b0;
        chk(cnt == 8, "R9 count", 32'(cnt), 8);
        chk(!saw_all, "R7 flush-all ignored while busy", 32'(saw_all), 0);
        chk(!inv_valid, "R7 range not restarted", 32'(inv_valid), 0);
        rd(3'd4, r); chk(r == 1, "R5 done after walk", r, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule